// File: doc/BRIEF.md
# Bidirectional Printer Port Register Block

This block sits on a byte-wide register bus and drives the pins of a bidirectional printer port. Software selects one of three byte registers with a 2-bit offset and a read or write strobe. The data register holds a byte that is driven onto eight data lines. The status register shows five printer inputs. The control register holds four handshake line bits, an interrupt enable and a direction bit.

The four handshake lines are open-collector. A line is either pulled low or released, and software reads back the real pin level, not the value it wrote. Three of the lines use inverted polarity and one uses true polarity. If software writes 0100b to the low control nibble, all four lines are released, and an external device can then use them as inputs. When the direction bit is set, the data drivers are turned off and a read of the data register returns the byte that an external device drives.

The acknowledge input goes through a synchronizer. A small state machine follows its level. The state machine has two states, `ACK_LOW` and `ACK_HIGH`. The transition `LOW_TO_HIGH` is taken on a synchronized rising level, and the transition `HIGH_TO_LOW` is taken on a synchronized falling level. If interrupts are enabled, the `LOW_TO_HIGH` transition emits a one-cycle interrupt request.

Top module: `pport_bidir_regs`

## Requirements
- R1: After reset the data latch is 0x00, the data drivers are on (`pd_oe`=1), control reads 0xC4, no handshake line is pulled low, and `irq` is 0.
- R2: A write to offset 0 latches `bus_wdata` onto `pd_out`, which holds that value until the next offset-0 write. A read of offset 0 returns the data pin levels `pd_in`.
- R3: Control bit 5 = 1 turns the data drivers off (`pd_oe`=0), and a data read returns the externally driven byte. The latch still accepts writes. The latched byte is driven again as soon as bit 5 is cleared.
- R4: Control bits 7 and 6 ignore writes and always read as 1. Offset 3 reads 0xFF and ignores writes.
- R5: `ctl_drive_low` bit i = 1 pulls handshake line i low. Control bits 0, 1 and 3 pull their line low when they are 1. Bit 2 pulls its line low when it is 0. Writing 0100b to bits 3..0 releases all four lines.
- R6: A control read returns the pin levels `ctl_pin_in` in bits 3..0. Bits 0, 1 and 3 are inverted and bit 2 is true. Bit 4 reads back the interrupt enable and bit 5 reads back the direction bit.
- R7: A status read returns {~busy, ack, paper_out, selected, error, 3'b111}, with the inputs taken through a 2-flop synchronizer.
- R8: When control bit 4 = 1, a rising level on `st_ack` gives `irq` high for exactly one cycle, after the third clock edge following the change.
- R9: No `irq` is produced while control bit 4 = 0, and none is produced on a falling `st_ack`.
- R10: `bus_rdata` is registered. It updates on the edge where `bus_rd` is sampled high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pd_out | output | 8 | Data latch driven to the data lines |
| pd_oe | output | 1 | Data driver enable |
| pd_in | input | 8 | Data line pin levels |
| ctl_drive_low | output | 4 | Open-collector pull-down per handshake line |
| ctl_pin_in | input | 4 | Handshake line pin levels |
| st_busy | input | 1 | Printer busy |
| st_ack | input | 1 | Acknowledge (active low) |
| st_paper_out | input | 1 | Paper out |
| st_selected | input | 1 | Printer selected |
| st_error | input | 1 | Error (active low) |
| irq | output | 1 | Interrupt request pulse |

## Verification
Register writes and read strobes take effect on the edge that samples them, so the bench reads `pd_out`, `pd_oe`, `ctl_drive_low` and `bus_rdata` at the falling edge that follows that edge. A status input change needs two edges to pass the synchronizer before a read can capture it, so the bench waits three cycles before reading. An `irq` is due after the third edge following an acknowledge rise. The bench therefore records, at each falling edge in a window, which cycle the pulse appears in and how many cycles it lasts, and it compares both against the cycle the requirement names.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int BYTE_W  = 8;
    localparam int HS_W    = 4;
    localparam int STAT_W  = 5;
    localparam int OFS_W   = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 2'd0,
        OFS_STAT = 2'd1,
        OFS_CTRL = 2'd2,
        OFS_NONE = 2'd3
    } reg_ofs_e;

    typedef enum logic {
        ACK_LOW  = 1'b0,
        ACK_HIGH = 1'b1
    } ack_state_e;

    // Handshake lines whose pin level is the inverse of the register bit
    localparam logic [HS_W-1:0] HS_INVERT = 4'b1011;
    // Register value that releases every handshake line
    localparam logic [HS_W-1:0] HS_IDLE   = 4'b0100;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int            W      = 1,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= RST_V;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pport_ack_fsm.sv
module pport_ack_fsm
    import pport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic int_en,
    output logic irq
);
    ack_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_LOW:  if (ack_s)  state_d = ACK_HIGH;  // LOW_TO_HIGH
            ACK_HIGH: if (!ack_s) state_d = ACK_LOW;   // HIGH_TO_LOW
            default:  state_d = ACK_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_HIGH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            unique case (state_q)
                ACK_LOW:  irq <= ack_s && int_en;
                ACK_HIGH: irq <= 1'b0;
                default:  irq <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [HS_W-1:0]   hs_pins,
    output logic [BYTE_W-1:0] data_q,
    output logic              dir_in_q,
    output logic              int_en_q,
    output logic [HS_W-1:0]   hs_drive_low,
    output logic [BYTE_W-1:0] ctrl_view
);
    logic [HS_W-1:0] hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            hs_q     <= HS_IDLE;
            dir_in_q <= 1'b0;
            int_en_q <= 1'b0;
        end else begin
            if (wr_data) data_q <= wdata;
            if (wr_ctrl) begin
                hs_q     <= wdata[HS_W-1:0];
                int_en_q <= wdata[4];
                dir_in_q <= wdata[5];
            end
        end
    end

    // Intended pin level per line; a low level becomes a pull-down
    logic [HS_W-1:0] hs_level;
    logic [HS_W-1:0] hs_seen;
    generate
        for (genvar i = 0; i < HS_W; i++) begin : g_hs
            if (HS_INVERT[i]) begin : g_inv
                assign hs_level[i] = ~hs_q[i];
                assign hs_seen[i]  = ~hs_pins[i];
            end else begin : g_true
                assign hs_level[i] = hs_q[i];
                assign hs_seen[i]  = hs_pins[i];
            end
            assign hs_drive_low[i] = ~hs_level[i];
        end
    endgenerate

    assign ctrl_view = {2'b11, dir_in_q, int_en_q, hs_seen};
endmodule

// File: rtl/pport_bidir_regs.sv
module pport_bidir_regs
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [HS_W-1:0]   ctl_drive_low,
    input  logic [HS_W-1:0]   ctl_pin_in,
    input  logic              st_busy,
    input  logic              st_ack,
    input  logic              st_paper_out,
    input  logic              st_selected,
    input  logic              st_error,
    output logic              irq
);
    reg_ofs_e ofs;
    assign ofs = reg_ofs_e'(bus_addr);

    logic              dir_in_q, int_en_q;
    logic [BYTE_W-1:0] ctrl_view;
    logic [STAT_W-1:0] stat_s;

    pport_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data     (bus_wr && ofs == OFS_DATA),
        .wr_ctrl     (bus_wr && ofs == OFS_CTRL),
        .wdata       (bus_wdata),
        .hs_pins     (ctl_pin_in),
        .data_q      (pd_out),
        .dir_in_q    (dir_in_q),
        .int_en_q    (int_en_q),
        .hs_drive_low(ctl_drive_low),
        .ctrl_view   (ctrl_view)
    );

    // order: busy, ack, paper_out, selected, error
    pport_sync #(.W(STAT_W), .STAGES(SYNC_STAGES), .RST_V(5'b01001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({st_busy, st_ack, st_paper_out, st_selected, st_error}),
        .q    (stat_s)
    );

    pport_ack_fsm u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .ack_s (stat_s[3]),
        .int_en(int_en_q),
        .irq   (irq)
    );

    assign pd_oe = ~dir_in_q;

    logic [BYTE_W-1:0] rd_mux;
    always_comb begin
        unique case (ofs)
            OFS_DATA: rd_mux = pd_in;
            OFS_STAT: rd_mux = {~stat_s[4], stat_s[3:0], 3'b111};
            OFS_CTRL: rd_mux = ctrl_view;
            default:  rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/pport_bidir_regs_chk.sv
module pport_bidir_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] pd_out,
    input logic [3:0] ctl_drive_low,
    input logic       int_en,
    input logic       irq
);
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) |=> $stable(pd_out));

    a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> pd_out == $past(bus_wdata));

    a_r5_release_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && bus_wdata[3:0] == 4'b0100) |=> ctl_drive_low == 4'b0000);

    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq);

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind pport_bidir_regs pport_bidir_regs_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pd_out       (pd_out),
    .ctl_drive_low(ctl_drive_low),
    .int_en       (int_en_q),
    .irq          (irq)
);

// File: tb/test_pport_bidir_regs.sv
`timescale 1ns/1ps
module test_pport_bidir_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pd_out, pd_in;
    logic       pd_oe, irq;
    logic [3:0] ctl_drive_low, ctl_pin_in;
    logic [7:0] ext_data = 8'h00;
    logic [3:0] ext_pull = 4'h0;
    logic       st_busy = 1'b0, st_ack = 1'b1, st_paper_out = 1'b0;
    logic       st_selected = 1'b1, st_error = 1'b1;
    int         n_checks = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    // Pin models: data bus and open-collector handshake lines
    assign pd_in      = pd_oe ? pd_out : ext_data;
    assign ctl_pin_in = ~(ctl_drive_low | ext_pull);

    pport_bidir_regs i_pport_bidir_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .ctl_drive_low(ctl_drive_low), .ctl_pin_in(ctl_pin_in),
        .st_busy(st_busy), .st_ack(st_ack), .st_paper_out(st_paper_out),
        .st_selected(st_selected), .st_error(st_error), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // {offset, write value, expected read-back}
    localparam logic [17:0] VEC [10] = '{
        {2'd0, 8'h55, 8'h55}, {2'd0, 8'hAA, 8'hAA}, {2'd0, 8'h00, 8'h00},
        {2'd0, 8'hFF, 8'hFF}, {2'd2, 8'h00, 8'hC0}, {2'd2, 8'h0F, 8'hCF},
        {2'd2, 8'h13, 8'hD3}, {2'd2, 8'hC4, 8'hC4}, {2'd2, 8'h1A, 8'hDA},
        {2'd3, 8'h12, 8'hFF}
    };

    // Watch irq over a window: returns first high cycle (1-based) and count
    task automatic irq_window(output int first, output int count);
        first = 0; count = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (irq) begin
                count++;
                if (first == 0) first = c;
            end
        end
    endtask

    initial begin
        logic [7:0] v;
        int first, count;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pd_out", pd_out, 8'h00);
        check("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
        check("R1 drive_low", {4'd0, ctl_drive_low}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(2'd2, v); check("R1 ctrl read", v, 8'hC4);

        // R2 R4 R6 R10 table walk
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], v);
            check("R2/R4/R6 table", v, VEC[i][7:0]);
            if (VEC[i][17:16] == 2'd0) check("R2 pd_out", pd_out, VEC[i][15:8]);
        end

        // R10 rdata holds without a read strobe
        @(negedge clk); bus_addr = 2'd1;
        repeat (2) @(negedge clk);
        check("R10 hold", bus_rdata, 8'hFF);

        // R5 polarity of pull-downs
        wr(2'd2, 8'h0F);
        check("R5 drive 0F", {4'd0, ctl_drive_low}, 8'h0B);
        wr(2'd2, 8'h00);
        check("R5 drive 00", {4'd0, ctl_drive_low}, 8'h04);
        wr(2'd2, 8'h04);
        check("R5 release", {4'd0, ctl_drive_low}, 8'h00);

        // R6 external pulls seen through open-collector read-back
        ext_pull = 4'hF;
        rd(2'd2, v); check("R6 all pulled", v, 8'hCB);
        ext_pull = 4'h4;
        rd(2'd2, v); check("R6 line2 pulled", v, 8'hC0);
        ext_pull = 4'h0;

        // R3 input mode
        wr(2'd0, 8'h66);
        ext_data = 8'h3C;
        wr(2'd2, 8'h24);
        check("R3 oe off", {7'd0, pd_oe}, 8'h00);
        rd(2'd0, v); check("R3 ext read", v, 8'h3C);
        wr(2'd0, 8'h99);
        rd(2'd0, v); check("R3 still ext", v, 8'h3C);
        wr(2'd2, 8'h04);
        check("R3 oe on", {7'd0, pd_oe}, 8'h01);
        rd(2'd0, v); check("R3 latch redriven", v, 8'h99);

        // R7 status
        rd(2'd1, v); check("R7 idle status", v, 8'hDF);
        @(negedge clk);
        st_busy = 1'b1; st_ack = 1'b0; st_paper_out = 1'b1;
        st_selected = 1'b0; st_error = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R7 active status", v, 8'h27);
        st_busy = 1'b0; st_paper_out = 1'b0; st_selected = 1'b1; st_error = 1'b1;

        // R9 no irq with enable off (ack currently low -> rise)
        wr(2'd2, 8'h04);
        repeat (4) @(negedge clk);
        st_ack = 1'b1;
        irq_window(first, count);
        check("R9 ie off", count[7:0], 8'd0);

        // R8 one pulse, third edge after rise
        wr(2'd2, 8'h14);
        @(negedge clk); st_ack = 1'b0;
        irq_window(first, count);
        check("R9 falling edge", count[7:0], 8'd0);
        st_ack = 1'b1;
        irq_window(first, count);
        check("R8 pulse count", count[7:0], 8'd1);
        check("R8 pulse cycle", first[7:0], 8'd3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule